// File: doc/BRIEF.md
# Reference Clock Loss and Lock Alarm

This block watches a reference clock from inside a free-running system clock domain and raises one combined fault flag. Two independent detectors feed it. A silence detector reports loss of signal when no reference edge has arrived for a programmable number of system cycles. A frequency checker counts reference edges over a fixed window of system cycles and compares the count with an expected value, allowing a programmable tolerance. It reports loss of lock when the reference is present but runs at the wrong rate.

Only a frequency fault asks downstream logic to shut its clock outputs off. A reference that has simply vanished raises the alarm, but the outputs keep running freely. The reference is brought into the system domain by toggling a flop on each reference rising edge. That toggle passes through a two-flop synchronizer, and an edge detector turns each change into a one-cycle pulse.

The lock state machine has four states:
- `ST_ACQUIRE`: entered on reset, not yet locked.
- `ST_LOCKED`: the reference frequency is good.
- `ST_FAULT`: a bad window has been seen.
- `ST_RECOVER`: one good window seen after a fault.

It has six transitions:
- acquire-to-locked on the first good window.
- locked-to-fault on a bad window.
- fault-to-recover on a good window.
- recover-to-locked on a second consecutive good window.
- recover-to-fault on a bad window.
- hold in any state when no counted window completes.

Top module: `ref_alarm_top`

## Requirements
- R1: `alarm` is 1 exactly when `los` or `lol` is 1; 0 means no fault.
- R2: During and after reset the block is in `ST_ACQUIRE`. Until the first good window completes, `alarm`=1, `lol`=1, `out_disable`=1 and `los`=0.
- R3: `los` rises once `los_limit` consecutive system cycles pass with no synchronized reference edge. It falls on the cycle after any synchronized edge, which is within a few system cycles of a reference rising edge.
- R4: A window lasts `WIN_CYC` system cycles. It is good when the absolute difference between its edge count and `exp_count` is at most `tol`, and bad otherwise. `exp_count` and `tol` are sampled in the window's last cycle.
- R5: A good window moves `ST_ACQUIRE` to `ST_LOCKED`. A bad window moves `ST_LOCKED` to `ST_FAULT`. `lol` is 0 only in `ST_LOCKED`.
- R6: From `ST_FAULT`, lock returns only after two consecutive good windows, passing through `ST_RECOVER`. A bad window in `ST_RECOVER` returns to `ST_FAULT`.
- R7: A window during which `los` was 1 in any cycle is discarded and causes no state change.
- R8: `out_disable` is 1 in every state except `ST_LOCKED`. `los` by itself never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ref_clk | input | 1 | monitored reference clock |
| exp_count | input | CNT_W | expected reference edges per window |
| tol | input | CNT_W | allowed deviation from `exp_count` |
| los_limit | input | TO_W | silent system cycles before loss of signal |
| alarm | output | 1 | combined fault flag, 1 = fault |
| los | output | 1 | loss-of-signal status |
| lol | output | 1 | loss-of-lock status |
| out_disable | output | 1 | request to stop clock outputs |

## Verification
The hardest case to reach from the ports is a window that would be judged bad but has to be discarded because the reference fell silent inside it. To make it deterministic, the stimulus stops the reference exactly on a window boundary, counting cycles from reset release. The silence timeout is set well under one window, so `los` rises inside that window. The state machine's path through `ST_RECOVER` back to `ST_FAULT` is reached the same way: the good/bad verdict is flipped by rewriting `exp_count` and `tol` in the middle of chosen windows. A sweep of reference periods then checks the lock verdict wherever the edge count is unambiguous.

// File: rtl/ref_alarm_pkg.sv
package ref_alarm_pkg;
    typedef enum logic [1:0] {
        ST_ACQUIRE = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_FAULT   = 2'd2,
        ST_RECOVER = 2'd3
    } lock_state_e;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    output logic edge_p
);
    logic tgl_q;
    logic s1_q, s2_q, s3_q;

    // toggles once per reference rising edge
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= ~tgl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= tgl_q;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign edge_p = s2_q ^ s3_q;
endmodule

// File: rtl/los_detect.sv
module los_detect #(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_p,
    input  logic [TO_W-1:0] limit,
    output logic            los
);
    logic [TO_W-1:0] quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= '0;
            los     <= 1'b0;
        end else if (edge_p) begin
            quiet_q <= '0;
            los     <= 1'b0;
        end else if (quiet_q >= limit) begin
            los     <= 1'b1;
        end else begin
            quiet_q <= quiet_q + 1'b1;
        end
    end
endmodule

// File: rtl/freq_window.sv
module freq_window #(
    parameter int WIN_CYC = 64,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_p,
    input  logic             los,
    input  logic [CNT_W-1:0] exp_count,
    input  logic [CNT_W-1:0] tol,
    output logic             win_done,
    output logic             win_good,
    output logic             win_valid
);
    localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [WW-1:0] LAST = WW'(WIN_CYC - 1);

    logic [WW-1:0]    wcnt_q;
    logic [CNT_W-1:0] ecnt_q;
    logic             taint_q;
    logic [CNT_W-1:0] cnt_now;
    logic [CNT_W-1:0] diff;

    always_comb begin
        cnt_now = (edge_p && (ecnt_q != '1)) ? ecnt_q + 1'b1 : ecnt_q;
        diff    = (cnt_now >= exp_count) ? cnt_now - exp_count : exp_count - cnt_now;
    end

    assign win_done  = (wcnt_q == LAST);
    assign win_good  = (diff <= tol);
    assign win_valid = !(taint_q || los);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q  <= '0;
            ecnt_q  <= '0;
            taint_q <= 1'b0;
        end else if (win_done) begin
            wcnt_q  <= '0;
            ecnt_q  <= '0;
            taint_q <= 1'b0;
        end else begin
            wcnt_q  <= wcnt_q + 1'b1;
            ecnt_q  <= cnt_now;
            taint_q <= taint_q | los;
        end
    end
endmodule

// File: rtl/ref_alarm_top.sv
module ref_alarm_top
    import ref_alarm_pkg::*;
#(
    parameter int WIN_CYC = 64,
    parameter int CNT_W   = 8,
    parameter int TO_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk,
    input  logic [CNT_W-1:0] exp_count,
    input  logic [CNT_W-1:0] tol,
    input  logic [TO_W-1:0]  los_limit,
    output logic             alarm,
    output logic             los,
    output logic             lol,
    output logic             out_disable
);
    logic edge_p;
    logic win_done, win_good, win_valid;
    lock_state_e state_q, state_d;

    ref_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_clk(ref_clk),
        .edge_p (edge_p)
    );

    los_detect #(.TO_W(TO_W)) u_los (
        .clk   (clk),
        .rst_n (rst_n),
        .edge_p(edge_p),
        .limit (los_limit),
        .los   (los)
    );

    freq_window #(.WIN_CYC(WIN_CYC), .CNT_W(CNT_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_p   (edge_p),
        .los      (los),
        .exp_count(exp_count),
        .tol      (tol),
        .win_done (win_done),
        .win_good (win_good),
        .win_valid(win_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACQUIRE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (win_done && win_valid) begin
            unique case (state_q)
                ST_ACQUIRE: if (win_good)  state_d = ST_LOCKED;
                ST_LOCKED:  if (!win_good) state_d = ST_FAULT;
                ST_FAULT:   if (win_good)  state_d = ST_RECOVER;
                ST_RECOVER: state_d = win_good ? ST_LOCKED : ST_FAULT;
                default:    state_d = ST_ACQUIRE;
            endcase
        end
    end

    always_comb begin
        lol         = (state_q != ST_LOCKED);
        out_disable = lol;
        alarm       = los | lol;
    end
endmodule

// File: rtl/ref_alarm_chk.sv
module ref_alarm_chk (
    input logic clk,
    input logic rst_n,
    input logic alarm,
    input logic los,
    input logic lol,
    input logic out_disable,
    input logic edge_p,
    input logic win_done
);
    p_alarm_covers_los_r1: assert property (@(posedge clk) disable iff (!rst_n)
        los |-> alarm);
    p_alarm_covers_lol_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lol |-> alarm);
    p_quiet_when_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!los && !lol) |-> !alarm);
    p_edge_clears_los_r3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_p |=> !los);
    p_los_needs_silence_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> !$past(edge_p));
    p_lock_on_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lol) |-> $past(win_done));
    p_fault_on_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lol) |-> $past(win_done));
    p_disable_only_lol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lol |-> !out_disable);
endmodule

bind ref_alarm_top ref_alarm_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alarm      (alarm),
    .los        (los),
    .lol        (lol),
    .out_disable(out_disable),
    .edge_p     (edge_p),
    .win_done   (win_done)
);

// File: tb/ref_alarm_top_tb_top.sv
`timescale 1ns/1ps
module ref_alarm_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 64;
    localparam int CW         = 8;
    localparam int TW         = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic [CW-1:0] exp_count = 8'd8;
    logic [CW-1:0] tol = 8'd2;
    logic [TW-1:0] los_limit = 8'd20;
    logic alarm, los, lol, out_disable;

    int  cyc = 0;
    int  n_vec = 0;
    int  n_bad = 0;
    bit  ref_run = 1'b1;
    int  half = 40;
    bit  finished = 1'b0;

    ref_alarm_top #(.WIN_CYC(WIN), .CNT_W(CW), .TO_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
        .exp_count(exp_count), .tol(tol), .los_limit(los_limit),
        .alarm(alarm), .los(los), .lol(lol), .out_disable(out_disable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    always begin
        if (ref_run) begin
            #(half) ref_clk = 1'b1;
            #(half) ref_clk = 1'b0;
        end else begin
            ref_clk = 1'b0;
            #1;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, expv, cyc);
        end
    endtask

    task automatic at_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic chk_all(input string req, input logic e_los, input logic e_lol);
        chk(req, "los", los, e_los);
        chk(req, "lol", lol, e_lol);
        chk(req, "alarm", alarm, e_los | e_lol);
        chk(req, "out_disable", out_disable, e_lol);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R2", 1'b0, 1'b1);
        rst_n = 1'b1;
        at_cyc(WIN - 1);
        chk_all("R2", 1'b0, 1'b1);
        at_cyc(WIN);
        chk_all("R5", 1'b0, 1'b0);
        // locked -> fault
        at_cyc(WIN + 10); exp_count = 0; tol = 0;
        at_cyc(2*WIN);    chk_all("R5", 1'b0, 1'b1);
        // fault -> recover -> locked
        at_cyc(2*WIN+10); exp_count = 8; tol = 2;
        at_cyc(3*WIN);    chk_all("R6", 1'b0, 1'b1);
        at_cyc(4*WIN);    chk_all("R6", 1'b0, 1'b0);
        // recover -> fault path
        at_cyc(4*WIN+10); exp_count = 0; tol = 0;
        at_cyc(5*WIN);    chk_all("R6", 1'b0, 1'b1);
        at_cyc(5*WIN+10); exp_count = 8; tol = 2;
        at_cyc(6*WIN);    chk_all("R6", 1'b0, 1'b1);
        at_cyc(6*WIN+10); exp_count = 0; tol = 0;
        at_cyc(7*WIN);    chk_all("R6", 1'b0, 1'b1);
        at_cyc(7*WIN+10); exp_count = 8; tol = 2;
        at_cyc(8*WIN);    chk_all("R6", 1'b0, 1'b1);
        at_cyc(9*WIN);    chk_all("R6", 1'b0, 1'b0);
        // silence from a window boundary: los only, windows discarded
        ref_run = 1'b0;
        at_cyc(9*WIN + 10);  chk("R3", "los early", los, 1'b0);
        at_cyc(9*WIN + 30);  chk_all("R8", 1'b1, 1'b0);
        chk("R1", "alarm on los", alarm, 1'b1);
        at_cyc(12*WIN);      chk_all("R7", 1'b1, 1'b0);
        ref_run = 1'b1;
        at_cyc(12*WIN + 14); chk_all("R3", 1'b0, 1'b0);
        at_cyc(14*WIN);      chk_all("R7", 1'b0, 1'b0);
        // period sweep, verdict checked where the count is unambiguous
        for (int p = 40; p <= 160; p += 4) begin
            int base;
            int f;
            bit surely_good;
            bit surely_bad;
            base = cyc;
            half = p / 2;
            f = (WIN * CLK_PERIOD) / p;
            surely_good = ((f - 1) >= 8 - 2) && ((f + 1) <= 8 + 2);
            surely_bad  = ((f + 1) < 8 - 2) || ((f - 1) > 8 + 2);
            at_cyc(base + 4*WIN);
            if (surely_good) chk("R4", "lol good period", lol, 1'b0);
            if (surely_bad)  chk("R4", "lol bad period", lol, 1'b1);
            if (surely_bad)  chk("R8", "out_disable bad period", out_disable, 1'b1);
        end
        finish_run();
    end
endmodule